// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings up to four SDRAM chip-select banks out of power-up without software involvement. A start pulse launches a walk over the banks in ascending index order. Each bank whose enable flag is set gets a settling wait, then four requests to a downstream command engine: precharge of all internal banks, two auto-refresh commands and a mode-register write. A second settling wait follows before the walk moves on. Banks whose enable flag is clear are passed over without any wait.

Requests go out one at a time. Each request waits for the engine's done response before the next is issued. An error response from the engine halts the walk and raises a sticky error flag. The mode-register word is built from a burst-length code and a CAS-latency code. A one-cycle done pulse marks a complete walk. The bank enables, page addresses and codes must be held stable while the block is busy.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, busy, done, err and cmd_req are all low.
- R2: A start pulse while idle raises busy in the next cycle and clears err. A start pulse while busy has no effect, and the request sequence continues unchanged.
- R3: Banks are visited in ascending index order. Every request for bank b carries cmd_addr equal to that bank's page input shifted left by 12, with zeros in bits 11:0. A bank with a clear enable flag takes one cycle and gets no requests.
- R4: Each enabled bank receives exactly four requests, in this order of cmd_op codes: 0 (precharge all), 1 (auto refresh), 1 (auto refresh), 2 (mode-register set).
- R5: For the mode-register request, cmd_wdata[1:0] equals burst_code, cmd_wdata[5:4] equals cas_code and all other bits are zero. These are burst-length codes 0..3 for bursts of 1, 2, 4 and 8, and CAS codes 1..3. For every other request, cmd_wdata is zero.
- R6: With DLY the settling parameter and k the number of skipped banks in between, the first request of an enabled bank appears DLY+2+k cycles after the start cycle when it is the first enabled bank. Otherwise it appears 2*DLY+2+k cycles after the cycle in which the previous bank's mode-register request was answered done.
- R7: Within a bank, the next request appears exactly one cycle after the cycle in which eng_done is presented.
- R8: cmd_req is high for exactly one cycle per request.
- R9: done is a one-cycle pulse with busy low. It comes DLY+2+k cycles after the last mode-register done, where k is the number of higher banks skipped. With no bank enabled, it comes NBANK+2 cycles after start.
- R10: If eng_err is presented while a request is outstanding, err is high and busy is low in the next cycle. No further request is issued. err stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse |
| bank_vld | input | NBANK | Per-bank enable flags |
| bank_page | input | NBANK*PAGE_W | Per-bank base page (address bits above 11) |
| burst_code | input | 2 | Burst-length code for the mode word |
| cas_code | input | 2 | CAS-latency code for the mode word |
| eng_done | input | 1 | Engine reports the outstanding request finished |
| eng_err | input | 1 | Engine reports the outstanding request failed |
| cmd_req | output | 1 | Request strobe to the engine |
| cmd_op | output | 2 | Request type: 0 precharge all, 1 refresh, 2 mode set |
| cmd_addr | output | PAGE_W+12 | Target bank base address |
| cmd_wdata | output | 8 | Mode-register word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky engine-error flag |

## Verification
Every result has a fixed latency in cycles from the stimulus that causes it. Busy and err follow start or an error response by one cycle. A same-bank request follows its done response by one cycle. A new bank's first request follows by DLY+2+k or 2*DLY+2+k cycles, and the final done pulse by DLY+2+k. The bench acts as the command engine. It keeps a cycle counter, stores the count at the falling edge where it drives start or a response, and compares the measured distance to each later request or pulse against these formulas. Each request's op, address and data word are checked when it appears.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int NBANK  = 4,
  parameter int PAGE_W = 20,
  parameter int DLY    = 2000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NBANK-1:0]          bank_vld,
  input  logic [NBANK*PAGE_W-1:0]   bank_page,
  input  logic [1:0]                burst_code,
  input  logic [1:0]                cas_code,
  input  logic                      eng_done,
  input  logic                      eng_err,
  output logic                      cmd_req,
  output logic [1:0]                cmd_op,
  output logic [PAGE_W+11:0]        cmd_addr,
  output logic [7:0]                cmd_wdata,
  output logic                      busy,
  output logic                      done,
  output logic                      err
);
  localparam int IW = $clog2(NBANK + 1);
  localparam int CW = $clog2(DLY + 1);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_PRE, S_ISSUE, S_WAIT, S_POST} st_t;

  st_t             st;
  logic [IW-1:0]   idx;
  logic [1:0]      step;
  logic [CW-1:0]   cnt;
  logic            cur_vld;
  logic [PAGE_W-1:0] cur_page;

  always_comb begin
    cur_vld  = 1'b0;
    cur_page = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (idx == IW'(i)) begin
        cur_vld  = bank_vld[i];
        cur_page = bank_page[i*PAGE_W +: PAGE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      idx  <= '0;
      step <= '0;
      cnt  <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st  <= S_SCAN;
          idx <= '0;
          err <= 1'b0;
        end
        S_SCAN: begin
          if (idx == IW'(NBANK)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else if (cur_vld) begin
            st  <= S_PRE;
            cnt <= CW'(DLY - 1);
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_PRE: begin
          if (cnt == '0) begin
            st   <= S_ISSUE;
            step <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: begin
          if (eng_err) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else if (eng_done) begin
            if (step == 2'd3) begin
              st  <= S_POST;
              cnt <= CW'(DLY - 1);
            end else begin
              step <= step + 1'b1;
              st   <= S_ISSUE;
            end
          end
        end
        S_POST: begin
          if (cnt == '0) begin
            st  <= S_SCAN;
            idx <= idx + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_req   = (st == S_ISSUE);
  assign busy      = (st != S_IDLE);
  assign cmd_op    = (step == 2'd0) ? 2'd0 : (step == 2'd3) ? 2'd2 : 2'd1;
  assign cmd_addr  = {cur_page, 12'h000};
  assign cmd_wdata = (step == 2'd3) ? {2'b00, cas_code, 2'b00, burst_code} : 8'h00;
endmodule

module sdram_init_seq_chk #(
  parameter int NBANK  = 4,
  parameter int PAGE_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        burst_code,
  input logic [1:0]        cas_code,
  input logic              cmd_req,
  input logic [1:0]        cmd_op,
  input logic [7:0]        cmd_wdata,
  input logic              busy,
  input logic              done,
  input logic              err
);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_req_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> busy);
  assert_op_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> (cmd_op != 2'd3));
  assert_mode_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_op == 2'd2) |-> (cmd_wdata == {2'b00, cas_code, 2'b00, burst_code}));
  assert_plain_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_op != 2'd2) |-> (cmd_wdata == 8'h00));
  assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> !cmd_req);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !err && $past(busy)));
  assert_done_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);
  assert_err_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !cmd_req));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.NBANK(NBANK), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .burst_code(burst_code),
  .cas_code(cas_code), .cmd_req(cmd_req), .cmd_op(cmd_op),
  .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .err(err)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;
  localparam int NB = 4;
  localparam int PW = 20;
  localparam int D  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NB-1:0] bank_vld = '0;
  logic [NB*PW-1:0] bank_page = '0;
  logic [1:0] burst_code = '0, cas_code = '0;
  logic eng_done = 1'b0, eng_err = 1'b0;
  logic cmd_req, busy, done, err;
  logic [1:0] cmd_op;
  logic [PW+11:0] cmd_addr;
  logic [7:0] cmd_wdata;

  int total = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_init_seq #(.NBANK(NB), .PAGE_W(PW), .DLY(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bank_vld(bank_vld),
    .bank_page(bank_page), .burst_code(burst_code), .cas_code(cas_code),
    .eng_done(eng_done), .eng_err(eng_err), .cmd_req(cmd_req),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .err(err));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_op(input int j);
    return (j == 0) ? 0 : (j == 3) ? 2 : 1;
  endfunction

  function automatic int exp_word(input int j, input logic [1:0] bl, input logic [1:0] cl);
    return (j == 3) ? int'({2'b00, cl, 2'b00, bl}) : 0;
  endfunction

  task automatic run(input logic [NB-1:0] vld, input logic [NB*PW-1:0] pg,
                     input logic [1:0] bl, input logic [1:0] cl,
                     input int err_at, input bit poke);
    int rf, n, gap, prev, ncmd, lat, seen;
    bit stopped;
    bank_vld = vld; bank_page = pg; burst_code = bl; cas_code = cl;
    start = 1'b1; rf = cyc;
    @(negedge clk); start = 1'b0;
    chk("R2", "busy after start", busy, 1);
    chk("R10", "err cleared by start", err, 0);
    prev = -1; ncmd = 0; stopped = 0;
    for (int b = 0; b < NB; b++) begin
      if (vld[b]) begin
        for (int j = 0; j < 4; j++) begin
          if (!stopped) begin
            n = 0;
            while (!cmd_req && n < 2000) begin @(negedge clk); n++; end
            gap = cyc - rf;
            if (j > 0) chk("R7", "gap in bank", gap, 1);
            else if (prev < 0) chk("R6", "first bank gap", gap, D + 2 + b);
            else chk("R6", "bank to bank gap", gap, 2*D + 2 + (b - prev - 1));
            chk("R4", "op", cmd_op, exp_op(j));
            chk("R3", "addr", cmd_addr, {pg[b*PW +: PW], 12'h000});
            chk("R5", "word", cmd_wdata, exp_word(j, bl, cl));
            lat = (poke && ncmd == 0) ? 3 : 1 + int'($urandom % 3);
            @(negedge clk);
            chk("R8", "req one cycle", cmd_req, 0);
            if (poke && ncmd == 0) start = 1'b1;
            for (int k = 1; k < lat; k++) begin
              @(negedge clk); start = 1'b0;
            end
            if (ncmd == err_at) eng_err = 1'b1; else eng_done = 1'b1;
            rf = cyc;
            @(negedge clk);
            if (eng_err) begin
              eng_err = 1'b0;
              chk("R10", "err set", err, 1);
              chk("R10", "busy dropped", busy, 0);
              seen = 0;
              for (int k = 0; k < 2*D + 10; k++) begin
                if (cmd_req) seen++;
                @(negedge clk);
              end
              chk("R10", "no request after error", seen, 0);
              chk("R10", "err sticky", err, 1);
              stopped = 1;
            end
            eng_done = 1'b0;
            ncmd++;
            if (j == 3) prev = b;
          end
        end
      end
    end
    if (!stopped) begin
      n = 0;
      seen = 0;
      while (!done && n < 2000) begin
        if (cmd_req) seen++;
        @(negedge clk); n++;
      end
      gap = cyc - rf;
      chk("R3", "no extra request", seen, 0);
      if (prev < 0) chk("R9", "done gap none valid", gap, NB + 2);
      else chk("R9", "done gap", gap, D + 2 + (NB - 1 - prev));
      chk("R9", "busy low at done", busy, 0);
      chk("R9", "no err at done", err, 0);
      @(negedge clk);
      chk("R9", "done one cycle", done, 0);
    end
  endtask

  initial begin
    #1200000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NB-1:0] v;
    logic [NB*PW-1:0] p;
    int nv, ea;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy reset", busy, 0);
    chk("R1", "done reset", done, 0);
    chk("R1", "err reset", err, 0);
    chk("R1", "req reset", cmd_req, 0);

    run(4'b1111, {20'hABCDE, 20'h12345, 20'h00F00, 20'h80001}, 2'd3, 2'd3, -1, 0);
    run(4'b0000, '0, 2'd0, 2'd1, -1, 0);
    run(4'b1000, {20'hFFFFF, 60'h0}, 2'd1, 2'd2, -1, 0);
    run(4'b0101, {20'h1, 20'h2, 20'h3, 20'h4}, 2'd2, 2'd1, -1, 1);
    run(4'b0011, {40'h0, 20'h55555, 20'hAAAAA}, 2'd0, 2'd3, 5, 0);
    run(4'b0001, {60'h0, 20'h00010}, 2'd2, 2'd2, -1, 0);

    for (int it = 0; it < 30; it++) begin
      v = NB'($urandom);
      for (int b = 0; b < NB; b++) p[b*PW +: PW] = PW'($urandom);
      nv = $countones(v);
      ea = (nv > 0 && ($urandom % 5) == 0) ? int'($urandom % (4*nv)) : -1;
      run(v, p, 2'($urandom), 2'(1 + $urandom % 3), ea, ($urandom % 4) == 0);
      repeat (int'($urandom % 3)) @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule